// File: doc/BRIEF.md
# Backlight PWM Dimming Controller

This block holds a 16-step backlight brightness level and turns it into a PWM waveform for the backlight driver. A single write port, which stands in for a brightness command arriving over the display's auxiliary channel, can load the level. Two push-button inputs can also move it up or down one step. Whenever the stored level changes, the block raises a one-cycle save request that carries the new value, so that outside storage can keep it. At reset the level is loaded from `init_level`, which is the value saved earlier.

The output has three modes. In bypass mode the external PWM input passes straight to the output. In multiply mode the block measures the period and high time of the external PWM in system clocks and reproduces that period with a scaled high time. In internal mode the block's own counter produces a waveform with a programmable period. A new level, period or mode is taken up only at the start of a period, so no runt pulse appears.

The command port is a valid/ready stream that never applies back-pressure: `cmd_ready` is always high, and every cycle with `cmd_valid` high is a transfer. All other pins are plain levels or strobes.

Top module: `bl_dimmer`

## Requirements
- R1: While `rst_n` is low, the level is loaded from `init_level`. After reset, `level` shows that value and `save_req` is low.
- R2: A cycle with `cmd_valid` high loads `cmd_level` into the level. `cmd_ready` is always 1, and a command takes priority over a button step in the same cycle.
- R3: `inc_btn` and `dec_btn` are two-flop synchronized and edge detected. Each press, however long it is held, moves the level by exactly one.
- R4: The level saturates. An increment at 15 leaves it at 15, and a decrement at 0 leaves it at 0. Neither case raises a save request.
- R5: `save_req` pulses for one cycle, with `save_level` equal to the new level, exactly when the level changes. Writing the current value raises no pulse.
- R6: In internal mode (`mode` = 0 or 3), each period lasts P = `period_cfg` cycles, with 0 treated as 1. The output is high for the first floor(P·L/15) cycles of each period, where L is the level, so L=0 is always low and L=15 is always high.
- R7: In bypass mode (`mode` = 1), `pwm_out` equals `pwm_in` in the same cycle.
- R8: In multiply mode (`mode` = 2), the output period equals the measured input period, counted between rising edges. Each output period is high for floor(H·L/15) cycles, where H is the measured input high time of the last complete input period.
- R9: In multiply mode, if `pwm_in` shows no rising edge for `TIMEOUT` cycles, the output is held low until two new rising edges give a fresh measurement.
- R10: Changes to the level, `period_cfg` or `mode` take effect only at the start of the next output period. The current period finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_level | input | 4 | Level loaded during reset |
| cmd_valid | input | 1 | Brightness command valid |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_level | input | 4 | Commanded level |
| inc_btn | input | 1 | Increment button, asynchronous |
| dec_btn | input | 1 | Decrement button, asynchronous |
| mode | input | 2 | 0/3 internal, 1 bypass, 2 multiply |
| period_cfg | input | CNT_W | Internal-mode period in clocks |
| pwm_in | input | 1 | External PWM input |
| pwm_out | output | 1 | Backlight PWM output |
| level | output | 4 | Current brightness level |
| save_req | output | 1 | One-cycle save request |
| save_level | output | 4 | Level to save, valid with `save_req` |

## Verification
Internal mode is swept over all 16 levels at periods of 1, 5, 15, 16 and 30 cycles. Counting high cycles over one period window checks the rounding of floor(P·L/15) at both ends and in the middle, without depending on phase. Multiply mode is swept over all levels with three input shapes (short duty, near-full duty, single-cycle pulse), which separates a scale by the measured high time from a scale by the period. Bypass is compared cycle by cycle against two input shapes. A level write in the middle of a period, the timeout with an idle input, and button presses at both saturation limits complete the set.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;
  localparam int LVL_W   = 4;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef enum logic [1:0] {
    MD_INT  = 2'd0,
    MD_BYP  = 2'd1,
    MD_MUL  = 2'd2,
    MD_INTB = 2'd3
  } bl_mode_e;
endpackage

// File: rtl/bl_level_ctrl.sv
module bl_level_ctrl
  import bl_dim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] init_level,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic             inc_btn,
  input  logic             dec_btn,
  output logic [LVL_W-1:0] lvl,
  output logic             save_req
);
  logic [2:0] up_sh, dn_sh;
  logic       up_edge, dn_edge, cmd_fire;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic       save_q;

  assign cmd_ready = 1'b1;
  assign cmd_fire  = cmd_valid & cmd_ready;
  assign up_edge   = up_sh[1] & ~up_sh[2];
  assign dn_edge   = dn_sh[1] & ~dn_sh[2];

  always_comb begin
    lvl_n = lvl_q;
    if (cmd_fire)
      lvl_n = cmd_level;
    else if (up_edge && !dn_edge && lvl_q != LVL_W'(LVL_MAX))
      lvl_n = lvl_q + 1'b1;
    else if (dn_edge && !up_edge && lvl_q != '0)
      lvl_n = lvl_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_sh  <= '0;
      dn_sh  <= '0;
      lvl_q  <= init_level;
      save_q <= 1'b0;
    end else begin
      up_sh  <= {up_sh[1:0], inc_btn};
      dn_sh  <= {dn_sh[1:0], dec_btn};
      lvl_q  <= lvl_n;
      save_q <= (lvl_n != lvl_q);
    end
  end

  assign lvl      = lvl_q;
  assign save_req = save_q;

  AST_SAVE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    save_q |-> (lvl_q != $past(lvl_q)));  // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |=> ((lvl_q == $past(lvl_q)) ||
                   ({1'b0, lvl_q} == {1'b0, $past(lvl_q)} + 5'd1) ||
                   ({1'b0, lvl_q} + 5'd1 == {1'b0, $past(lvl_q)})));  // R3
endmodule

// File: rtl/bl_pwm_meter.sv
module bl_pwm_meter #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  output logic             meas_ok,
  output logic [CNT_W-1:0] meas_per,
  output logic [CNT_W-1:0] meas_hi
);
  localparam logic [CNT_W-1:0] TO_CNT = CNT_W'(TIMEOUT);

  logic [2:0]       sh;
  logic             rise, seen_q, ok_q;
  logic [CNT_W-1:0] pc_q, hc_q, per_q, hi_q;

  assign rise = sh[1] & ~sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; seen_q <= 1'b0; ok_q <= 1'b0;
      pc_q <= '0; hc_q <= '0; per_q <= '0; hi_q <= '0;
    end else begin
      sh <= {sh[1:0], pwm_in};
      if (rise) begin
        per_q  <= pc_q;
        hi_q   <= hc_q;
        pc_q   <= CNT_W'(1);
        hc_q   <= CNT_W'(1);
        seen_q <= 1'b1;
        ok_q   <= seen_q;
      end else begin
        if (pc_q < TO_CNT) pc_q <= pc_q + 1'b1;
        if (sh[1] && hc_q < TO_CNT) hc_q <= hc_q + 1'b1;
        if (pc_q >= TO_CNT) begin
          ok_q   <= 1'b0;
          seen_q <= 1'b0;
        end
      end
    end
  end

  assign meas_ok  = ok_q;
  assign meas_per = per_q;
  assign meas_hi  = hi_q;

  AST_IDLE_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q >= TO_CNT && !rise) |=> !ok_q);  // R9

  AST_MEAS_HI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> (hi_q <= per_q));  // R8
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_dim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] lvl,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic             meas_ok,
  input  logic [CNT_W-1:0] meas_per,
  input  logic [CNT_W-1:0] meas_hi,
  input  logic             pwm_in,
  output logic             pwm_out
);
  localparam int PW = CNT_W + LVL_W;

  bl_mode_e         mode_in, mode_q;
  logic [CNT_W-1:0] cnt_q, per_q, hi_q, per_n, base_n, hi_n;
  logic [PW-1:0]    prod;
  logic             last;

  assign mode_in = bl_mode_e'(mode);
  assign last    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};

  always_comb begin
    case (mode_in)
      MD_BYP: begin
        per_n  = CNT_W'(1);
        base_n = '0;
      end
      MD_MUL: begin
        per_n  = meas_ok ? meas_per : CNT_W'(1);
        base_n = meas_ok ? meas_hi  : '0;
      end
      default: begin
        per_n  = (period_cfg == '0) ? CNT_W'(1) : period_cfg;
        base_n = per_n;
      end
    endcase
    prod = PW'(base_n) * PW'(lvl);
    hi_n = CNT_W'(prod / PW'(LVL_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_INT;
      cnt_q  <= '0;
      per_q  <= CNT_W'(1);
      hi_q   <= '0;
    end else if (last) begin
      mode_q <= mode_in;
      cnt_q  <= '0;
      per_q  <= (per_n == '0) ? CNT_W'(1) : per_n;
      hi_q   <= hi_n;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (mode_q)
      MD_BYP:  pwm_out = pwm_in;
      MD_MUL:  pwm_out = (cnt_q < hi_q) && meas_ok;
      default: pwm_out = (cnt_q < hi_q);
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> ($stable(hi_q) && $stable(per_q) && $stable(mode_q)));  // R10

  AST_HIGH_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q <= per_q);  // R6
endmodule

// File: rtl/bl_dimmer.sv
module bl_dimmer #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       init_level,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_level,
  input  logic             inc_btn,
  input  logic             dec_btn,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic             pwm_in,
  output logic             pwm_out,
  output logic [3:0]       level,
  output logic             save_req,
  output logic [3:0]       save_level
);
  logic [3:0]       lvl;
  logic             meas_ok;
  logic [CNT_W-1:0] meas_per, meas_hi;

  bl_level_ctrl u_lvl (
    .clk(clk), .rst_n(rst_n), .init_level(init_level),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_level(cmd_level),
    .inc_btn(inc_btn), .dec_btn(dec_btn), .lvl(lvl), .save_req(save_req)
  );

  bl_pwm_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .meas_ok(meas_ok), .meas_per(meas_per), .meas_hi(meas_hi)
  );

  bl_pwm_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lvl(lvl),
    .period_cfg(period_cfg), .meas_ok(meas_ok), .meas_per(meas_per),
    .meas_hi(meas_hi), .pwm_in(pwm_in), .pwm_out(pwm_out)
  );

  assign level      = lvl;
  assign save_level = lvl;
endmodule

// File: tb/bl_dimmer_test.sv
`timescale 1ns/1ps
module bl_dimmer_test;
  localparam int CW = 16;
  localparam int TO = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] init_level = 4'd9, cmd_level = '0;
  logic cmd_valid = 1'b0, inc_btn = 1'b0, dec_btn = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [CW-1:0] period_cfg = CW'(10);
  logic pwm_in = 1'b0;
  logic cmd_ready, pwm_out, save_req;
  logic [3:0] level, save_level;

  int checks = 0, errors = 0;
  int save_cnt = 0, last_save = -1;
  int in_per = 10, in_hi = 3, in_en = 0, ph = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bl_dimmer #(.CNT_W(CW), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .init_level(init_level),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_level(cmd_level),
    .inc_btn(inc_btn), .dec_btn(dec_btn), .mode(mode), .period_cfg(period_cfg),
    .pwm_in(pwm_in), .pwm_out(pwm_out), .level(level),
    .save_req(save_req), .save_level(save_level)
  );

  // external PWM source, updated at negedge
  initial forever begin
    @(negedge clk);
    if (in_en != 0) begin
      ph = (ph + 1 >= in_per) ? 0 : ph + 1;
      pwm_in = (ph < in_hi);
    end else begin
      pwm_in = 1'b0;
    end
  end

  // save strobe monitor
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && save_req) begin
      save_cnt++;
      last_save = save_level;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_level(input int v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_level = 4'(v);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic press(input bit up);
    @(negedge clk);
    if (up) inc_btn = 1'b1; else dec_btn = 1'b1;
    repeat (8) @(negedge clk);
    inc_btn = 1'b0; dec_btn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (pwm_out) c++;
    end
  endtask

  initial begin
    int plist[5] = '{1, 5, 15, 16, 30};
    int pin[3] = '{20, 9, 25};
    int hin[3] = '{7, 8, 1};
    int c, s0, mism;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    chk(level == 4'd9, "R1 level after reset", level, 9);
    chk(save_cnt == 0, "R1 no save after reset", save_cnt, 0);
    chk(cmd_ready == 1'b1, "R2 cmd_ready", cmd_ready, 1);

    // R2 command write
    set_level(3); @(negedge clk); #1;
    chk(level == 4'd3, "R2 command load", level, 3);

    // R5 save on change / not on same value
    s0 = save_cnt;
    set_level(11); repeat (2) @(negedge clk);
    chk(save_cnt == s0 + 1, "R5 save pulse count", save_cnt, s0 + 1);
    chk(last_save == 11, "R5 save value", last_save, 11);
    set_level(11); repeat (2) @(negedge clk);
    chk(save_cnt == s0 + 1, "R5 no save on same value", save_cnt, s0 + 1);

    // R3 single step per held press
    press(1'b1); #1;
    chk(level == 4'd12, "R3 increment one step", level, 12);
    chk(last_save == 12, "R5 save after button", last_save, 12);
    press(1'b0); press(1'b0); #1;
    chk(level == 4'd10, "R3 decrement two presses", level, 10);

    // R4 saturation
    set_level(15); repeat (2) @(negedge clk);
    s0 = save_cnt;
    press(1'b1); #1;
    chk(level == 4'd15, "R4 saturate high", level, 15);
    chk(save_cnt == s0, "R4 no save at top", save_cnt, s0);
    set_level(0); repeat (2) @(negedge clk);
    s0 = save_cnt;
    press(1'b0); #1;
    chk(level == 4'd0, "R4 saturate low", level, 0);
    chk(save_cnt == s0, "R4 no save at bottom", save_cnt, s0);

    // R6 internal mode sweep
    mode = 2'd0;
    foreach (plist[k]) begin
      period_cfg = CW'(plist[k]);
      for (int l = 0; l < 16; l++) begin
        set_level(l);
        repeat (70) @(negedge clk);
        count_high(plist[k], c);
        chk(c == plist[k] * l / 15, $sformatf("R6 P=%0d L=%0d high count", plist[k], l),
            c, plist[k] * l / 15);
      end
    end
    period_cfg = '0; set_level(15); repeat (70) @(negedge clk);
    count_high(10, c);
    chk(c == 10, "R6 period 0 acts as 1 at L=15", c, 10);
    mode = 2'd3; set_level(0); repeat (70) @(negedge clk);
    count_high(10, c);
    chk(c == 0, "R6 mode 3 internal L=0", c, 0);

    // R10 level change mid-period waits for period start
    mode = 2'd0; period_cfg = CW'(30); set_level(5);
    repeat (80) @(negedge clk); #1;
    while (pwm_out) begin @(negedge clk); #1; end
    while (!pwm_out) begin @(negedge clk); #1; end
    repeat (15) @(negedge clk);
    cmd_valid = 1'b1; cmd_level = 4'd15;
    @(negedge clk); cmd_valid = 1'b0; #1;
    c = pwm_out ? 1 : 0;
    begin
      int c2;
      count_high(13, c2); c += c2;
    end
    chk(c == 0, "R10 old duty holds to period end", c, 0);
    count_high(30, c);
    chk(c == 30, "R10 new duty from next period", c, 30);

    // R7 bypass
    mode = 2'd2; mode = 2'd1;
    in_en = 1; in_per = 7; in_hi = 3;
    repeat (40) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (pwm_out != pwm_in) mism++;
      if (i == 30) begin in_per = 4; in_hi = 2; end
    end
    chk(mism == 0, "R7 bypass follows input", mism, 0);

    // R8 multiply sweep
    mode = 2'd2;
    foreach (pin[k]) begin
      in_per = pin[k]; in_hi = hin[k];
      for (int l = 0; l < 16; l++) begin
        set_level(l);
        repeat (5 * pin[k] + 40) @(negedge clk);
        count_high(pin[k], c);
        chk(c == hin[k] * l / 15,
            $sformatf("R8 Pin=%0d Hin=%0d L=%0d high count", pin[k], hin[k], l),
            c, hin[k] * l / 15);
      end
    end

    // R9 timeout holds output low
    set_level(15); in_per = 10; in_hi = 6;
    repeat (80) @(negedge clk);
    count_high(10, c);
    chk(c == 6, "R9 active before timeout", c, 6);
    in_en = 0;
    repeat (TO + 40) @(negedge clk);
    count_high(50, c);
    chk(c == 0, "R9 low after input idle", c, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule